// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly Engine

This block performs the path-metric recursion of a 32-state Viterbi decoder. One radix-2 butterfly is time-shared over the trellis, so a whole column of 32 states takes 16 clock cycles. For each decoded bit it pops one pair of signed soft values from an upstream first-word-fall-through symbol FIFO. It forms the four possible branch metrics once and steers them to the butterfly according to the code bits of each branch. Path metrics live in two 32-entry metric memories. One is read as the old column while the other is written as the new column, and the two swap roles at every column boundary.

The engine writes one 32-bit survivor-decision word per column, together with a one-cycle strobe, into a downstream traceback memory. Metrics are unsigned, and a smaller metric means a more likely path. The engine keeps them bounded by subtracting a fixed amount from a whole column once any metric has crossed half of its range.

Top module: `vit_acs_engine`

## Requirements
- R1: While reset is low and afterwards, `col_done` and `dec_word` read 0 until the first column ends. For the 16 cycles after reset release (cycles 0 to 15, counted from the cycle in which `rst_n` rises), the engine initialises the metric memory and `sym_rd` stays low. If data is waiting, the first pop happens in cycle 16.
- R2: `sym_rd` is high only while `sym_avail` is high. An idle engine pops in the same cycle in which data becomes available. While data keeps coming, pops are exactly 16 cycles apart, and never closer.
- R3: `col_done` is a single-cycle pulse. It is high in the 17th cycle after the cycle in which the matching symbol was popped, and `dec_word` holds that column's decisions in the same cycle. There is exactly one pulse per popped symbol.
- R4: The branch metric for expected code bits (c0,c1) is `(c0 ? -a : a) + (c1 ? -b : b) + 256`, where `a` = `sym_a` and `b` = `sym_b` are two's-complement values in -128..127 and a positive value favours code bit 1. For the move from old state p (5 bits) with input bit u, c0 is the parity of `6'b110101 & {u,p}` and c1 is the parity of `6'b101111 & {u,p}`.
- R5: New state n takes the cheaper of two candidates: old state `{n[3:0],0}` (the upper branch) and old state `{n[3:0],1}` (the lower branch), with u = n[4]. Bit n of `dec_word` is 1 when the lower branch survives and 0 when the upper one survives. A tie resolves to 0.
- R6: The first column after reset starts from metric 0 for state 0 and metric 4096 for every other state.
- R7: When any metric written in a column is 32768 or more, every metric written in the next column is reduced by 16384. Over hundreds of columns the decision words are identical to those of unbounded arithmetic, and no written metric reaches 49152.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_avail | input | 1 | Symbol FIFO holds at least one entry |
| sym_a | input | 8 | First soft value at the FIFO head, signed |
| sym_b | input | 8 | Second soft value at the FIFO head, signed |
| sym_rd | output | 1 | Pop strobe; the head is consumed at this clock edge |
| col_done | output | 1 | One-cycle strobe marking a finished column |
| dec_word | output | 32 | Survivor decisions of the finished column, bit n for state n |

## Verification
A reference trellis with unbounded integer metrics runs beside the engine and predicts every decision word. A noise-free encoded stream at ±100 shows whether the butterfly wiring, the branch-metric polarity and the generator taps are right, starting from the skewed initial metrics. All-zero soft values make every surviving path equal, which exposes the tie rule. Extreme ±128/127 values probe the edges of the branch-metric range. A run of 400 columns of small random values drives the metrics through several normalisation events, where any wrap or uneven subtraction would change decisions. An idle gap with an empty FIFO, followed by refills, separates the idle-start timing from the back-to-back column timing.

// File: rtl/vit_acs_engine.sv
module vit_acs_engine #(
  parameter int SOFT_W = 8,
  parameter int PM_W   = 16,
  parameter int NST    = 32,
  parameter logic [5:0] POLY0 = 6'b110101,
  parameter logic [5:0] POLY1 = 6'b101111
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sym_avail,
  input  logic signed [SOFT_W-1:0] sym_a,
  input  logic signed [SOFT_W-1:0] sym_b,
  output logic                     sym_rd,
  output logic                     col_done,
  output logic [NST-1:0]           dec_word
);
  localparam int SB    = $clog2(NST);
  localparam int HALF  = NST / 2;
  localparam int JB    = SB - 1;
  localparam int BM_W  = SOFT_W + 3;
  localparam int OFS   = 2 ** SOFT_W;
  localparam logic [PM_W-1:0] LARGE = PM_W'(2 ** (PM_W - 4));
  localparam logic [PM_W-1:0] NORM  = PM_W'(2 ** (PM_W - 2));
  localparam logic [JB-1:0]   JLAST = JB'(HALF - 1);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_RUN} st_t;

  st_t st;
  logic [JB-1:0] j;
  logic bank, norm_pend, norm_seen;
  logic signed [SOFT_W-1:0] sa, sb;
  logic [NST-1:0] dec_acc, dec_nxt;
  logic [PM_W-1:0] pm [2][NST];

  function automatic logic [1:0] code_of(input logic u, input logic [SB-1:0] p);
    logic [SB:0] r;
    r = {u, p};
    return {^(POLY0 & r), ^(POLY1 & r)};
  endfunction

  function automatic logic [PM_W-1:0] norm_sub(input logic [PM_W-1:0] v);
    return (v >= NORM) ? v - NORM : '0;
  endfunction

  logic signed [BM_W-1:0] ea, eb;
  logic [BM_W-1:0] bm [4];
  assign ea = {{(BM_W-SOFT_W){sa[SOFT_W-1]}}, sa};
  assign eb = {{(BM_W-SOFT_W){sb[SOFT_W-1]}}, sb};

  for (genvar k = 0; k < 4; k++) begin : g_bm
    localparam logic [1:0] KC = 2'(k);
    assign bm[k] = (KC[1] ? -ea : ea) + (KC[0] ? -eb : eb) + BM_W'(OFS);
  end

  logic [SB-1:0] p0, p1;
  logic [PM_W-1:0] rd0, rd1, lo_a, lo_b, hi_a, hi_b, sel_lo, sel_hi, new_lo, new_hi;
  logic dec_lo, dec_hi, last;

  assign p0   = {j, 1'b0};
  assign p1   = {j, 1'b1};
  assign rd0  = pm[bank][p0];
  assign rd1  = pm[bank][p1];
  assign lo_a = rd0 + PM_W'(bm[code_of(1'b0, p0)]);
  assign lo_b = rd1 + PM_W'(bm[code_of(1'b0, p1)]);
  assign hi_a = rd0 + PM_W'(bm[code_of(1'b1, p0)]);
  assign hi_b = rd1 + PM_W'(bm[code_of(1'b1, p1)]);
  assign dec_lo = lo_b < lo_a;
  assign dec_hi = hi_b < hi_a;
  assign sel_lo = dec_lo ? lo_b : lo_a;
  assign sel_hi = dec_hi ? hi_b : hi_a;
  assign new_lo = norm_pend ? norm_sub(sel_lo) : sel_lo;
  assign new_hi = norm_pend ? norm_sub(sel_hi) : sel_hi;

  assign last   = (st == S_RUN) && (j == JLAST);
  assign sym_rd = sym_avail && ((st == S_IDLE) || last);

  logic wr_en, wr_bank;
  logic [PM_W-1:0] wr_lo_val, wr_hi_val;
  assign wr_en     = (st != S_IDLE);
  assign wr_bank   = (st == S_INIT) ? bank : ~bank;
  assign wr_lo_val = (st == S_INIT) ? ((j == '0) ? '0 : LARGE) : new_lo;
  assign wr_hi_val = (st == S_INIT) ? LARGE : new_hi;

  always_ff @(posedge clk)
    if (wr_en) begin
      pm[wr_bank][{1'b0, j}] <= wr_lo_val;
      pm[wr_bank][{1'b1, j}] <= wr_hi_val;
    end

  always_comb begin
    dec_nxt = dec_acc;
    dec_nxt[{1'b0, j}] = dec_lo;
    dec_nxt[{1'b1, j}] = dec_hi;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_INIT;
      j         <= '0;
      bank      <= 1'b0;
      sa        <= '0;
      sb        <= '0;
      norm_pend <= 1'b0;
      norm_seen <= 1'b0;
      dec_acc   <= '0;
      dec_word  <= '0;
      col_done  <= 1'b0;
    end else begin
      col_done <= 1'b0;
      if (sym_rd) begin
        sa <= sym_a;
        sb <= sym_b;
      end
      case (st)
        S_INIT: begin
          j <= j + 1'b1;
          if (j == JLAST) st <= S_IDLE;
        end
        S_IDLE: if (sym_rd) begin
          st <= S_RUN;
          j  <= '0;
        end
        default: begin
          j       <= j + 1'b1;
          dec_acc <= dec_nxt;
          if (last) begin
            bank      <= ~bank;
            col_done  <= 1'b1;
            dec_word  <= dec_nxt;
            norm_pend <= norm_seen | new_lo[PM_W-1] | new_hi[PM_W-1];
            norm_seen <= 1'b0;
            if (!sym_rd) st <= S_IDLE;
          end else begin
            norm_seen <= norm_seen | new_lo[PM_W-1] | new_hi[PM_W-1];
          end
        end
      endcase
    end
endmodule

// File: rtl/vit_acs_engine_chk.sv
module vit_acs_engine_chk #(
  parameter int PM_W = 16,
  parameter int HALF = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sym_avail,
  input logic            sym_rd,
  input logic            col_done,
  input logic            wr_en,
  input logic [PM_W-1:0] wr_lo,
  input logic [PM_W-1:0] wr_hi
);
  localparam int CW = $clog2(HALF) + 1;
  localparam logic [PM_W-1:0] CEIL = PM_W'(3 * 2 ** (PM_W - 2));

  logic [CW-1:0] since_rst, gap;
  logic          seen_pop;
  logic [2:0]    outst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      since_rst <= '0;
      gap       <= '0;
      seen_pop  <= 1'b0;
      outst     <= '0;
    end else begin
      if (since_rst != CW'(HALF)) since_rst <= since_rst + 1'b1;
      if (sym_rd) begin
        gap      <= CW'(1);
        seen_pop <= 1'b1;
      end else if (gap != CW'(HALF)) gap <= gap + 1'b1;
      outst <= outst + 3'(sym_rd) - 3'(col_done);
    end

  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < CW'(HALF)) |-> !sym_rd);
  p_pop_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_rd |-> sym_avail);
  p_pop_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_rd && seen_pop) |-> (gap == CW'(HALF)));
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_done |=> !col_done);
  p_done_has_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_done |-> (outst != 3'd0));
  p_metric_headroom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_lo < CEIL) && (wr_hi < CEIL)));
endmodule

bind vit_acs_engine vit_acs_engine_chk #(.PM_W(PM_W), .HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_avail(sym_avail), .sym_rd(sym_rd),
  .col_done(col_done), .wr_en(wr_en), .wr_lo(wr_lo_val), .wr_hi(wr_hi_val)
);

// File: tb/vit_acs_engine_bench.sv
module vit_acs_engine_bench;
  localparam logic [5:0] G0 = 6'b110101;
  localparam logic [5:0] G1 = 6'b101111;

  logic clk = 1'b0, rst_n = 1'b0, sym_avail = 1'b0;
  logic signed [7:0] sym_a = '0, sym_b = '0;
  logic sym_rd, col_done;
  logic [31:0] dec_word;

  always #10 clk = ~clk;

  vit_acs_engine u_vit_acs_engine (
    .clk(clk), .rst_n(rst_n), .sym_avail(sym_avail), .sym_a(sym_a), .sym_b(sym_b),
    .sym_rd(sym_rd), .col_done(col_done), .dec_word(dec_word)
  );

  int checks = 0, failures = 0;
  int qa[$], qb[$], popc[$];
  logic [31:0] expw[$];
  string exptag[$];
  int pm[32];
  int cyc = 0, last_pop = -1, sent = 0, dones = 0;
  bit go = 0, pend = 0, first_pop = 1;

  function automatic int bmf(int u, int p, int a, int b);
    logic [5:0] r;
    r = {u[0], p[4:0]};
    return ((^(G0 & r)) ? -a : a) + ((^(G1 & r)) ? -b : b) + 256;
  endfunction

  task automatic ref_reset();
    for (int n = 0; n < 32; n++) pm[n] = (n == 0) ? 0 : 4096;
  endtask

  task automatic send(int a, int b, string tag);
    int nm[32];
    logic [31:0] w;
    for (int n = 0; n < 32; n++) begin
      int u, p0, ca, cb;
      u = n >> 4;
      p0 = (n & 15) << 1;
      ca = pm[p0] + bmf(u, p0, a, b);
      cb = pm[p0 + 1] + bmf(u, p0 + 1, a, b);
      w[n] = (cb < ca);
      nm[n] = (cb < ca) ? cb : ca;
    end
    pm = nm;
    qa.push_back(a);
    qb.push_back(b);
    expw.push_back(w);
    exptag.push_back(tag);
    sent++;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drain();
    while (expw.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    wait (go);
    forever begin
      if (pend) begin
        void'(qa.pop_front());
        void'(qb.pop_front());
        pend = 0;
      end
      sym_avail = (qa.size() != 0);
      sym_a = (qa.size() != 0) ? 8'(qa[0]) : '0;
      sym_b = (qb.size() != 0) ? 8'(qb[0]) : '0;
      #1;
      if (sym_rd) begin
        chk(sym_avail, "R2 pop with empty fifo", 0, 1);
        if (first_pop) chk(cyc == 16, "R1 first pop cycle", cyc, 16);
        else if (cyc - last_pop < 16) chk(0, "R2 pop spacing", cyc - last_pop, 16);
        first_pop = 0;
        last_pop = cyc;
        popc.push_back(cyc);
        pend = 1;
      end else if (sym_avail && !first_pop && cyc == last_pop + 16) begin
        chk(0, "R2 back-to-back pop missing", 0, 1);
      end
      if (col_done) begin
        dones++;
        if (expw.size() == 0) chk(0, "R3 unexpected col_done", 1, 0);
        else begin
          logic [31:0] w;
          string t;
          int pc;
          w = expw.pop_front();
          t = exptag.pop_front();
          pc = popc.pop_front();
          chk(cyc - pc == 17, "R3 done latency", cyc - pc, 17);
          checks++;
          if (dec_word !== w) begin
            failures++;
            $display("FAIL %s dec_word actual=%h expected=%h", t, dec_word, w);
          end
        end
      end
      @(negedge clk);
      cyc++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int es;
    ref_reset();
    repeat (4) @(negedge clk);
    chk(col_done == 1'b0, "R1 col_done in reset", int'(col_done), 0);
    es = 0;
    for (int i = 0; i < 40; i++) begin
      logic [5:0] r;
      int u;
      u = (((i * 7 + 3) % 5) < 2) ? 1 : 0;
      r = {u[0], es[4:0]};
      send((^(G0 & r)) ? 100 : -100, (^(G1 & r)) ? 100 : -100, "R4 R5 R6 clean stream");
      es = (u << 4) | (es >> 1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    go = 1;
    #2;
    chk(col_done == 1'b0, "R1 col_done after release", int'(col_done), 0);
    chk(dec_word == '0, "R1 dec_word after release", int'(dec_word), 0);
    drain();

    for (int i = 0; i < 10; i++) send(0, 0, "R5 tie rule zero input");
    drain();

    for (int i = 0; i < 12; i++)
      send((i % 2) ? 127 : -128, (i % 3 == 0) ? -128 : 127, "R4 extreme values");
    drain();

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #3;
      if (sym_rd || col_done) break;
    end
    chk(!sym_rd && !col_done, "R2 idle with empty fifo", int'(sym_rd), 0);

    send(50, -30, "R2 idle restart");
    drain();

    for (int i = 0; i < 400; i++)
      send(int'($urandom_range(0, 40)) - 20, int'($urandom_range(0, 40)) - 20,
           "R7 long run normalisation");
    drain();

    chk(dones == sent, "R3 one pulse per symbol", dones, sent);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule